// File: doc/BRIEF.md
# Sync-Triggered Hold-Off Timer

This block delays the start of a new gain-loop decimation period by a programmable number of clock cycles after a synchronisation event. Two sources raise a sync on equal terms. One is an external sync pin, which is synchronised and edge-detected. The other is a single-cycle software "sync now" pulse. An accepted sync loads a 16-bit delay value into a down-counter. When the counter reaches zero, the block emits a one-cycle update strobe, and the gain loop uses that strobe to begin a fresh decimation period.

A new accepted sync reloads the counter even while a count is running, so the timer behaves as a retriggerable one-shot. A delay value of zero means the loop is not to be synchronised, so a sync that arrives while the value is zero does nothing.

A first-sync-only mode lets software synchronise exactly once. While the mode is on, only the first accepted sync takes effect and later ones are ignored. Turning the mode off re-arms the block.

Top module: `sync_holdoff_timer`

## Requirements
- R1: While reset is asserted and after it is released with no sync, `updateStrobe` and `busy` are both 0.
- R2: A software sync given with `holdCount` = N > 0 in the cycle before clock edge E loads N at E. `updateStrobe` is then high for exactly one cycle, in the cycle after clock edge E+N.
- R3: A rising edge on `syncPin` is accepted two clock edges after the edge that first samples the pin high, so it loads at the third edge. A pin held high counts as a single event.
- R4: An accepted sync while a count is running reloads the counter. Only one strobe follows, N+1 cycles after the latest sync.
- R5: A sync presented while `holdCount` is 0 is ignored. It loads nothing, leaves a running count undisturbed, produces no strobe and does not use up the first-sync-only slot.
- R6: While `firstOnly` is 1, only the first accepted sync loads the counter. Later syncs from either source are ignored.
- R7: Driving `firstOnly` to 0 for at least one clock re-arms the block, so the next sync is accepted again.
- R8: `busy` is high in exactly N cycles per accepted load that runs to completion, and it is low in the cycle the strobe is high.
- R9: `holdCount` is sampled only when a sync is accepted. Changing it during a running count does not change when the strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncPin | input | 1 | External sync pin, asynchronous to clk |
| syncNow | input | 1 | Single-cycle software sync pulse |
| firstOnly | input | 1 | First-sync-only mode enable |
| holdCount | input | 16 | Programmed hold-off delay in cycles, 0 disables synchronisation |
| updateStrobe | output | 1 | One-cycle pulse when the hold-off delay expires |
| busy | output | 1 | High while the hold-off counter is non-zero |

## Verification
A counter that loads the wrong value, or fails to decrement, moves the strobe away from the N+1 or N+3 cycle position predicted for each sync. The same fault changes the number of cycles `busy` stays high, so it shows within one delay window. A first-only latch stuck set or never set shows on the very next sync as a missing or unexpected strobe. A zero value that slips through shows as a load that ends a running count early. A pin edge detector that fires on level rather than edge shows as repeated reloads while the pin is held, which pushes the strobe later than predicted.

// File: rtl/holdoff_pkg.sv
package holdoff_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture the programmed delay
    logic dec;   // step the running count down by one
  } holdoff_ctl_t;
endpackage

// File: rtl/holdoff_pin_edge.sv
module holdoff_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinRise
);
  logic [STAGES-1:0] chain;
  logic lastLvl;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= 1'b0;
      else if (i == 0) chain[i] <= pinIn;
      else chain[i] <= chain[(i > 0) ? i - 1 : 0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLvl <= 1'b0;
    else lastLvl <= chain[STAGES-1];
  end

  assign pinRise = chain[STAGES-1] & ~lastLvl;

  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinRise |=> !pinRise);
endmodule

// File: rtl/holdoff_ctrl.sv
module holdoff_ctrl
  import holdoff_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinRise,
  input  logic             swSync,
  input  logic             firstOnly,
  input  logic [CNT_W-1:0] holdValue,
  input  logic             busy,
  output holdoff_ctl_t     ctl
);
  logic armedDone;
  logic trigger;
  logic accept;

  assign trigger = pinRise | swSync;
  assign accept  = trigger && (holdValue != '0) && !(firstOnly && armedDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedDone <= 1'b0;
    else if (!firstOnly) armedDone <= 1'b0;
    else if (accept) armedDone <= 1'b1;
  end

  always_comb begin
    ctl.load = accept;
    ctl.dec  = busy & ~accept;
  end

  // R6
  first_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (firstOnly && $past(firstOnly) && $past(ctl.load)) |-> !ctl.load);
endmodule

// File: rtl/holdoff_datapath.sv
module holdoff_datapath
  import holdoff_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  holdoff_ctl_t     ctl,
  input  logic [CNT_W-1:0] holdValue,
  output logic             updateStrobe,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (ctl.load) count <= holdValue;
    else if (ctl.dec) count <= count - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updateStrobe <= 1'b0;
    else updateStrobe <= ctl.dec && (count == ONE);
  end

  assign busy = (count != '0);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> count == $past(holdValue));
  // R5
  zero_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> busy);
  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |=> !updateStrobe);
  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStrobe |-> (!busy && $past(busy)));
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.load) |=> count == $past(count) - ONE);
endmodule

// File: rtl/sync_holdoff_timer.sv
module sync_holdoff_timer
  import holdoff_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncPin,
  input  logic             syncNow,
  input  logic             firstOnly,
  input  logic [CNT_W-1:0] holdCount,
  output logic             updateStrobe,
  output logic             busy
);
  holdoff_ctl_t ctl;
  logic pinRise;

  holdoff_pin_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rstN(rstN), .pinIn(syncPin), .pinRise(pinRise)
  );

  holdoff_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pinRise(pinRise), .swSync(syncNow),
    .firstOnly(firstOnly), .holdValue(holdCount), .busy(busy), .ctl(ctl)
  );

  holdoff_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .holdValue(holdCount),
    .updateStrobe(updateStrobe), .busy(busy)
  );
endmodule

// File: tb/test_sync_holdoff_timer.sv
module test_sync_holdoff_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncPin = 1'b0;
  logic syncNow = 1'b0;
  logic firstOnly = 1'b0;
  logic [15:0] holdCount = '0;
  logic updateStrobe, busy;

  int cyc = 0, strobeCnt = 0, busyCnt = 0, lastStrobe = -1;
  int checks = 0, fails = 0;

  // {isPin, delay}
  localparam logic [16:0] VECS [7] = '{
    {1'b0, 16'd1}, {1'b0, 16'd5}, {1'b1, 16'd1}, {1'b1, 16'd7},
    {1'b0, 16'd0}, {1'b1, 16'd3}, {1'b0, 16'd300}
  };

  always #2 clk = ~clk;

  sync_holdoff_timer i_sync_holdoff_timer (
    .clk(clk), .rstN(rstN), .syncPin(syncPin), .syncNow(syncNow),
    .firstOnly(firstOnly), .holdCount(holdCount),
    .updateStrobe(updateStrobe), .busy(busy)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (updateStrobe) begin strobeCnt++; lastStrobe = cyc; end
    if (busy) busyCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic swSync(input int v, output int t);
    @(negedge clk);
    holdCount = 16'(v); syncNow = 1'b1; t = cyc;
    @(negedge clk);
    syncNow = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t, t2, s0, b0;
    waitN(3);
    check(!updateStrobe && !busy, "R1 in reset", {updateStrobe, busy}, 0);
    rstN = 1'b1;
    waitN(3);
    check(!updateStrobe && !busy, "R1 after reset", {updateStrobe, busy}, 0);

    // table walk: R2, R3, R5, R8
    foreach (VECS[i]) begin
      int n;
      bit isPin;
      n = int'(VECS[i][15:0]);
      isPin = VECS[i][16];
      s0 = strobeCnt; b0 = busyCnt;
      if (isPin) begin
        @(negedge clk);
        holdCount = 16'(n); syncPin = 1'b1; t = cyc;
        waitN(n + 12);
        syncPin = 1'b0;
        waitN(5);
      end else begin
        swSync(n, t);
        waitN(n + 12);
      end
      if (n == 0) begin
        check(strobeCnt == s0, "R5 zero delay no strobe", strobeCnt - s0, 0);
        check(busyCnt == b0, "R5 zero delay no busy", busyCnt - b0, 0);
      end else begin
        check(strobeCnt - s0 == 1, isPin ? "R3 held pin one strobe" : "R2 one strobe",
              strobeCnt - s0, 1);
        check(lastStrobe == t + n + (isPin ? 3 : 1), isPin ? "R3 pin latency" : "R2 latency",
              lastStrobe - t, n + (isPin ? 3 : 1));
        check(busyCnt - b0 == n, "R8 busy width", busyCnt - b0, n);
      end
    end

    // R4 retrigger
    s0 = strobeCnt;
    swSync(10, t);
    waitN(3);
    swSync(6, t2);
    waitN(20);
    check(strobeCnt - s0 == 1, "R4 single strobe", strobeCnt - s0, 1);
    check(lastStrobe == t2 + 7, "R4 reload latency", lastStrobe - t2, 7);

    // R5 zero during a running count
    s0 = strobeCnt;
    swSync(8, t);
    waitN(1);
    swSync(0, t2);
    waitN(15);
    check(strobeCnt - s0 == 1, "R5 zero leaves count", strobeCnt - s0, 1);
    check(lastStrobe == t + 9, "R5 zero leaves timing", lastStrobe - t, 9);

    // R9 value change mid-count
    s0 = strobeCnt;
    swSync(9, t);
    holdCount = 16'd2;
    waitN(15);
    check(lastStrobe == t + 10, "R9 sampled at accept", lastStrobe - t, 10);

    // R6 first-only mode
    @(negedge clk); firstOnly = 1'b1;
    s0 = strobeCnt;
    swSync(4, t);
    waitN(10);
    check(lastStrobe == t + 5, "R6 first sync accepted", lastStrobe - t, 5);
    s0 = strobeCnt; b0 = busyCnt;
    swSync(4, t);
    waitN(10);
    @(negedge clk); syncPin = 1'b1;
    waitN(8);
    syncPin = 1'b0;
    waitN(8);
    check(strobeCnt == s0, "R6 later syncs ignored strobe", strobeCnt - s0, 0);
    check(busyCnt == b0, "R6 later syncs ignored busy", busyCnt - b0, 0);

    // R7 re-arm, R5 zero does not consume slot
    @(negedge clk); firstOnly = 1'b0;
    waitN(2);
    firstOnly = 1'b1;
    s0 = strobeCnt; b0 = busyCnt;
    swSync(0, t);
    waitN(4);
    check(busyCnt == b0, "R5 zero in first-only", busyCnt - b0, 0);
    swSync(3, t);
    waitN(8);
    check(strobeCnt - s0 == 1, "R7 re-armed strobe", strobeCnt - s0, 1);
    check(lastStrobe == t + 4, "R7 re-armed latency", lastStrobe - t, 4);
    firstOnly = 1'b0;
    waitN(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule